// File: doc/BRIEF.md
# Key Switch Matrix Scanner

This block reads a diode-isolated array of key switches, 8 rows by 6 columns. It selects one row at a time through a 3-bit row index. An enable strobe tells the external row multiplexer to pull that row low. After a programmable settle time, the block latches the column lines and two extra lines into an 8-bit parallel-load shift register. It then clocks that register out serially with its own shift clock. Each serial byte is decoded into the six switch bits of the current row.

After all eight rows have been captured, the block compares the new image with the image from the scan before it. The published 48-bit switch map takes a new value only when two successive complete scans are identical. A single-cycle pulse marks each published change. The two extra register inputs are expected to be tied high on the board. A low on either one flags a fault, and the scan in progress then cannot be used for agreement.

Top module: `keymatrix_scan`

## Requirements
- R1: During and directly after reset, `row_stb`, `sw_changed` and `pad_err` are 0, `sw_state` is all zero and `row_sel` is 7.
- R2: Rows are visited in the order 0,1,…,7,0,… with `row_sel` constant while `row_stb` is high. `row_stb` drops for exactly one cycle between rows, and `row_sel` advances by one (modulo 8) in that low cycle.
- R3: `row_stb` stays high for SETTLE_CYC + 2 + 8·SHIFT_DIV cycles per row, which is 38 cycles with the defaults. This covers the settle wait, one load cycle, eight shift-clock periods and one decode cycle.
- R4: `col_n[c]` (c = 0..5) is the active-low column c. A closed switch at row r, column c appears as `sw_state[r*6+c] = 1`, and an open switch as 0.
- R5: `sw_state` changes only when two consecutive complete scans (rows 0 to 7) produce identical images. A disturbance captured in only one scan never reaches `sw_state`.
- R6: `sw_changed` is a one-cycle pulse. It is high in exactly the cycle in which `sw_state` takes a value different from its previous one, and never otherwise. That cycle immediately follows the decode of row 7, so `row_sel` still reads 7.
- R7: `col_n[7:6]` are padding lines that must be high at capture. A low on either gives a one-cycle `pad_err` pulse after that row is decoded. That row's byte is discarded, and its scan counts neither as a match nor as the reference for the next scan.
- R8: Any set of closed switches is reported at once and independently, including bit 0, bit 47, a whole row and all 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | input | 8 | Column lines [5:0] (active low), padding lines [7:6] (expected high) |
| row_sel | output | 3 | Index of the row being driven |
| row_stb | output | 1 | High while the selected row is driven low |
| sw_state | output | 48 | Debounced switch map, bit r*6+c, 1 = closed |
| sw_changed | output | 1 | One-cycle pulse when `sw_state` takes a new value |
| pad_err | output | 1 | One-cycle pulse when a padding line was captured low |

## Verification
The assertions assume that `col_n` reflects only the row being driven, and that it remains steady for at least the settle time before the load cycle. The bench meets this by deriving `col_n` combinationally from `row_sel`, `row_stb` and a model key map. It changes the map only on falling clock edges. The short-disturbance case is kept well below one scan period, so it can reach at most one captured row.

// File: rtl/keymatrix_scan.sv
module keymatrix_scan #(
  parameter int N_ROWS     = 8,
  parameter int N_COLS     = 6,
  parameter int N_PAD      = 2,
  parameter int SETTLE_CYC = 4,
  parameter int SHIFT_DIV  = 4,
  localparam int REG_W = N_COLS + N_PAD,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int MAP_W = N_ROWS * N_COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] col_n,
  output logic [ROW_W-1:0] row_sel,
  output logic             row_stb,
  output logic [MAP_W-1:0] sw_state,
  output logic             sw_changed,
  output logic             pad_err
);
  localparam int HALF  = SHIFT_DIV / 2;
  localparam int CMAX  = (SETTLE_CYC > SHIFT_DIV) ? SETTLE_CYC : SHIFT_DIV;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int BIT_W = $clog2(REG_W + 1);

  typedef enum logic [2:0] {S_NEXT, S_SETTLE, S_LOAD, S_SHIFT, S_DECODE} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic [REG_W-1:0] sreg, rx;
  logic [MAP_W-1:0] scan_buf, scan_nxt, prev_scan;
  logic             scan_ok, prev_ok;
  logic             pad_ok, last_row;

  assign row_stb  = (st != S_NEXT);
  assign pad_ok   = &rx[REG_W-1:N_COLS];
  assign last_row = (row_sel == ROW_W'(N_ROWS - 1));

  always_comb begin
    scan_nxt = scan_buf;
    scan_nxt[row_sel*N_COLS +: N_COLS] = ~rx[N_COLS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_NEXT;
      row_sel    <= ROW_W'(N_ROWS - 1);
      cnt        <= '0;
      bitn       <= '0;
      sreg       <= '1;
      rx         <= '1;
      scan_buf   <= '0;
      prev_scan  <= '0;
      scan_ok    <= 1'b1;
      prev_ok    <= 1'b0;
      sw_state   <= '0;
      sw_changed <= 1'b0;
      pad_err    <= 1'b0;
    end else begin
      sw_changed <= 1'b0;
      pad_err    <= 1'b0;
      unique case (st)
        S_NEXT: begin
          row_sel <= last_row ? '0 : row_sel + 1'b1;
          cnt     <= '0;
          st      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOAD: begin
          sreg <= col_n;
          bitn <= '0;
          cnt  <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (cnt == CNT_W'(HALF - 1)) begin
            rx   <= {sreg[0], rx[REG_W-1:1]};
            sreg <= {1'b1, sreg[REG_W-1:1]};
            bitn <= bitn + 1'b1;
          end
          if (cnt == CNT_W'(SHIFT_DIV - 1)) begin
            cnt <= '0;
            if (bitn == BIT_W'(REG_W)) st <= S_DECODE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DECODE: begin
          if (pad_ok) scan_buf <= scan_nxt;
          else begin
            pad_err <= 1'b1;
            scan_ok <= 1'b0;
          end
          if (last_row) begin
            if (scan_ok && pad_ok) begin
              if (prev_ok && scan_nxt == prev_scan) begin
                sw_state   <= scan_nxt;
                sw_changed <= (scan_nxt != sw_state);
              end
              prev_scan <= scan_nxt;
              prev_ok   <= 1'b1;
            end else begin
              prev_ok <= 1'b0;
            end
            scan_ok <= 1'b1;
          end
          st <= S_NEXT;
        end
        default: st <= S_NEXT;
      endcase
    end
  end
endmodule

// File: rtl/keymatrix_scan_chk.sv
module keymatrix_scan_chk #(
  parameter int N_ROWS = 8,
  parameter int ROW_W  = 3,
  parameter int MAP_W  = 48,
  parameter int PERIOD = 38
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_sel,
  input logic             row_stb,
  input logic [MAP_W-1:0] sw_state,
  input logic             sw_changed,
  input logic             pad_err
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= '0;
    else if (row_stb) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;

  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb && $past(row_stb) |-> $stable(row_sel));

  p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb) |-> row_sel == (($past(row_sel) == ROW_W'(N_ROWS - 1)) ? '0 : ROW_W'($past(row_sel) + 1'b1)));

  p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb) |=> row_stb);

  p_row_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb) |-> hi_cnt == 16'(PERIOD));

  p_chg_differs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_changed |-> sw_state != $past(sw_state));

  p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_changed |-> $stable(sw_state));

  p_chg_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_changed |-> row_sel == ROW_W'(N_ROWS - 1) && !row_stb);

  p_chg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_changed |=> !sw_changed);

  p_pad_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_err |=> !pad_err);
endmodule

bind keymatrix_scan keymatrix_scan_chk #(
  .N_ROWS(N_ROWS), .ROW_W(ROW_W), .MAP_W(MAP_W),
  .PERIOD(SETTLE_CYC + 2 + REG_W * SHIFT_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .row_stb(row_stb),
  .sw_state(sw_state), .sw_changed(sw_changed), .pad_err(pad_err)
);

// File: tb/sim_keymatrix_scan.sv
`timescale 1ns/1ps
module sim_keymatrix_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  col_n;
  logic [2:0]  row_sel;
  logic        row_stb;
  logic [47:0] sw_state;
  logic        sw_changed, pad_err;

  logic [47:0] keys = '0;
  logic [1:0]  pad_n = 2'b11;
  int          n_chk = 0, n_bad = 0;
  bit          pad_seen = 0, done = 0;

  localparam int SCAN = 8 * 39;

  always #2.5 clk = ~clk;

  keymatrix_scan u0 (.clk(clk), .rst_n(rst_n), .col_n(col_n), .row_sel(row_sel),
                     .row_stb(row_stb), .sw_state(sw_state), .sw_changed(sw_changed),
                     .pad_err(pad_err));

  always_comb begin
    col_n[7:6] = pad_n;
    for (int c = 0; c < 6; c++)
      col_n[c] = ~(row_stb && keys[int'(row_sel)*6 + c]);
  end

  always @(negedge clk) if (pad_err) pad_seen = 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_change(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sw_changed) begin
        seen = 1;
        check(row_sel == 3'd7, "R6 row at pulse", 64'(row_sel), 64'd7);
        @(negedge clk);
        check(!sw_changed, "R6 pulse width", 64'(sw_changed), 64'd0);
        return;
      end
    end
  endtask

  task automatic t_reset();
    check(row_stb == 0 && sw_changed == 0 && pad_err == 0, "R1 controls", {61'd0, row_stb, sw_changed, pad_err}, 64'd0);
    check(sw_state == '0, "R1 state", 64'(sw_state), 64'd0);
    check(row_sel == 3'd7, "R1 row", 64'(row_sel), 64'd7);
  endtask

  task automatic t_rows();
    logic [2:0] exp_row = 3'd0;
    for (int r = 0; r < 10; r++) begin
      int hi = 0;
      while (!row_stb) @(negedge clk);
      check(row_sel == exp_row, "R2 order", 64'(row_sel), 64'(exp_row));
      while (row_stb) begin
        check(row_sel == exp_row, "R2 hold", 64'(row_sel), 64'(exp_row));
        hi++;
        @(negedge clk);
      end
      check(hi == 38, "R3 period", 64'(hi), 64'd38);
      @(negedge clk);
      check(row_stb == 1'b1, "R2 gap", 64'(row_stb), 64'd1);
      exp_row = exp_row + 3'd1;
    end
  endtask

  task automatic t_press(input logic [47:0] m, input string req);
    bit seen;
    keys = m;
    wait_change(4 * SCAN, seen);
    check(seen, req, 64'(seen), 64'd1);
    check(sw_state == m, req, 64'(sw_state), 64'(m));
  endtask

  task automatic t_same();
    bit seen;
    logic [47:0] old = sw_state;
    keys = old;
    wait_change(4 * SCAN, seen);
    check(!seen, "R6 no pulse on equal scans", 64'(seen), 64'd0);
    check(sw_state == old, "R6 state held", 64'(sw_state), 64'(old));
  endtask

  task automatic t_glitch();
    bit seen;
    logic [47:0] old = sw_state;
    keys = '1;
    repeat (10) @(negedge clk);
    keys = old;
    wait_change(4 * SCAN, seen);
    check(!seen, "R5 glitch filtered", 64'(seen), 64'd0);
    check(sw_state == old, "R5 state after glitch", 64'(sw_state), 64'(old));
  endtask

  task automatic t_pad();
    bit seen;
    logic [47:0] old = sw_state;
    pad_seen = 0;
    pad_n = 2'b01;
    keys = 48'h0000_0F00_0003;
    wait_change(4 * SCAN, seen);
    check(pad_seen, "R7 pad error flagged", 64'(pad_seen), 64'd1);
    check(!seen && sw_state == old, "R7 bad scans discarded", 64'(sw_state), 64'(old));
    pad_n = 2'b11;
    t_press(48'h0000_0F00_0003, "R7 recovery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rows();
    t_press(48'h0000_0000_0001, "R4 row0 col0");
    t_press(48'h8000_0000_0000, "R8 bit47");
    t_press(48'h0000_0000_0FC0, "R8 full row1");
    t_press(48'h0000_0420_0000, "R4 two rows");
    t_same();
    t_glitch();
    t_press(48'hFFFF_FFFF_FFFF, "R8 all closed");
    t_pad();
    t_press(48'h0, "R4 all open");
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule